// File: doc/BRIEF.md
# Multi-source reset controller with cause log

This block merges every reset request of the chip into one system reset and keeps a log of what caused it. Three kinds of request feed it. The power-on detect drives the block's own active-low reset. An external active-low pin and a precise low-voltage trip arrive asynchronously. A watchdog timeout and a software reset strobe arrive as single-cycle synchronous pulses. Asynchronous requests pull the system reset low at once. The reset is released only on a clock edge, and only after a counted minimum width.

Per-rail early-warning flags from the voltage monitors set sticky bits and raise a processor interrupt instead of a reset. Firmware reads the log after restart and clears bits by writing ones. The reset-cause field is replaced on every new reset event. The warning bits survive every reset except power-on.

In sleep mode the supervisors are only sampled during short periodic windows. The block produces the sampling enable and ignores trips and warnings that arrive outside a window. In hibernate mode supervision is fully off.

Top module: `rst_hub`

## Requirements
- R1: While rst_ni is low, sys_rst_no is low and status_o reads 1 (only bit 0, the power-on cause, set). After rst_ni rises, sys_rst_no goes high after exactly MIN_CYC clock edges.
- R2: A low on xres_ni drives sys_rst_no low without waiting for a clock edge. The pin sets status bit 2. After the pin returns high, sys_rst_no rises on the (MIN_CYC+2)-th clock edge.
- R3: A digital low-voltage trip gives the same response as R2 and sets status bit 1. The analog trip does the same, but only while ana_reg_en_i is 1; otherwise it has no effect.
- R4: A watchdog timeout pulse sampled on edge k holds sys_rst_no low from edge k until it rises on edge k+MIN_CYC. It sets status bit 3.
- R5: A software strobe sampled on edge k gives the same reset as R4 and sets status bit 4.
- R6: Every new reset request replaces the cause field (bits 4:0) with the set of sources requesting in that cycle. Requests in the same cycle each set their own bit, and bit 0 is cleared.
- R7: A one in clr_i clears the matching status bit, for bits 1 and up. Bit 0 cannot be cleared. A set in the same cycle takes priority over a clear.
- R8: warn_i[r] passes through a two-flop synchronizer. If warn_en_i[r] is 1, it sets sticky status bit 5+r. irq_o is the OR of the warning bits. Warning bits are kept across non-power-on resets.
- R9: pwr_mode_i encodes 0 = active, 1 = sleep, 2 or 3 = hibernate. In sleep, buzz_o is high when the count of edges since sleep was entered, taken modulo BUZZ_PERIOD, is at least BUZZ_PERIOD-BUZZ_WIDTH. buzz_o is low in every other mode.
- R10: Low-voltage trips and warnings are honoured in active mode, and in sleep only while buzz_o is high. In hibernate they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on detect, active low, asynchronous |
| xres_ni | input | 1 | External reset pin, active low, asynchronous |
| lvd_dig_trip_i | input | 1 | Digital precise low-voltage trip, asynchronous |
| lvd_ana_trip_i | input | 1 | Analog precise low-voltage trip, asynchronous |
| ana_reg_en_i | input | 1 | Analog regulator enabled; 0 masks the analog trip |
| warn_i | input | NRAIL | Per-rail early-warning flags |
| warn_en_i | input | NRAIL | Per-rail interrupt enable for the warnings |
| wdt_timeout_i | input | 1 | Watchdog expiry pulse |
| sw_rst_i | input | 1 | Software reset strobe |
| pwr_mode_i | input | 2 | Power mode: 0 active, 1 sleep, 2/3 hibernate |
| clr_i | input | 5+NRAIL | Write-one-to-clear strobe for the status bits |
| sys_rst_no | output | 1 | System reset, active low |
| irq_o | output | 1 | Early voltage-warning interrupt |
| status_o | output | 5+NRAIL | Cause bits 4:0 (por, lvd, ext, wdt, sw), warning bits above |
| buzz_o | output | 1 | Supervisor sampling enable in sleep |

## Verification
Two pairs of events can land on the same clock edge. The first is the watchdog pulse together with the software strobe. The bench drives both high for a single cycle and expects the cause field to read 24: both bits set and the power-on bit gone. The second is a software strobe together with a clear of its own status bit. The bench drives both in the same cycle and expects bit 4 to read back as set. Both outcomes are judged at the status port on the edge after the stimulus.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int CAUSE_W = 5;
  typedef enum int unsigned {
    C_POR = 0, C_LVD = 1, C_EXT = 2, C_WDT = 3, C_SW = 4
  } cause_e;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0, PM_SLEEP = 2'd1, PM_HIBER = 2'd2, PM_OFF = 2'd3
  } pmode_e;
endpackage

// File: rtl/rst_hub_catch.sv
// async assert, two-edge synchronous release
module rst_hub_catch (
  input  logic clk_i,
  input  logic src_ni,
  output logic hold_o
);
  logic [1:0] q;
  always_ff @(posedge clk_i or negedge src_ni) begin
    if (!src_ni) q <= 2'b11;
    else         q <= {q[0], 1'b0};
  end
  assign hold_o = q[1];
endmodule

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1  <= '0;
      q_o <= '0;
    end else begin
      s1  <= d_i;
      q_o <= s1;
    end
  end
endmodule

// File: rtl/rst_hub_buzz.sv
module rst_hub_buzz #(
  parameter int PERIOD = 1024,
  parameter int WIDTH  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic win_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] OPEN  = CW'(PERIOD - WIDTH);

  logic [CW-1:0] bcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bcnt <= '0;
    else if (!sleep_i) bcnt <= '0;
    else if (bcnt == LAST) bcnt <= '0;
    else               bcnt <= bcnt + 1'b1;
  end
  assign win_o = sleep_i && (bcnt >= OPEN);

  a_r9_window_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> sleep_i && $past(sleep_i));
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
  parameter int MIN_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic pulse_i,
  output logic rst_no
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_CYC);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= LOAD;
    else if (hold_i || pulse_i) cnt <= LOAD;
    else if (cnt != '0)         cnt <= cnt - 1'b1;
  end
  assign rst_no = !(hold_i || (cnt != '0));

  a_r4_pulse_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !rst_no);
  a_r4_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(!hold_i && !pulse_i));
endmodule

// File: rtl/rst_hub_status.sv
module rst_hub_status
  import rst_hub_pkg::*;
#(
  parameter int NRAIL = 4,
  localparam int SW   = CAUSE_W + NRAIL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] cause_req_i,
  input  logic [NRAIL-1:0]   warn_set_i,
  input  logic [SW-1:1]      clr_i,
  output logic [SW-1:0]      status_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause;
  logic [NRAIL-1:0]   warn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause <= CAUSE_W'(1);
      warn  <= '0;
    end else begin
      if (|cause_req_i) cause <= cause_req_i;
      else              cause <= cause & ~{clr_i[CAUSE_W-1:1], 1'b0};
      warn <= (warn & ~clr_i[SW-1:CAUSE_W]) | warn_set_i;
    end
  end

  assign status_o = {warn, cause};
  assign irq_o    = |warn;

  a_r7_por_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(status_o[C_POR]));
  a_r6_cause_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_req_i) |=> (status_o[CAUSE_W-1:0] == $past(cause_req_i)));
  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|warn_set_i));
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int NRAIL       = 4,
  parameter int MIN_CYC     = 32,
  parameter int BUZZ_PERIOD = 1024,
  parameter int BUZZ_WIDTH  = 16,
  localparam int SW         = CAUSE_W + NRAIL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xres_ni,
  input  logic             lvd_dig_trip_i,
  input  logic             lvd_ana_trip_i,
  input  logic             ana_reg_en_i,
  input  logic [NRAIL-1:0] warn_i,
  input  logic [NRAIL-1:0] warn_en_i,
  input  logic             wdt_timeout_i,
  input  logic             sw_rst_i,
  input  logic [1:0]       pwr_mode_i,
  input  logic [SW-1:0]    clr_i,
  output logic             sys_rst_no,
  output logic             irq_o,
  output logic [SW-1:0]    status_o,
  output logic             buzz_o
);
  logic is_active, is_sleep, mon_active;
  assign is_active = (pwr_mode_i == PM_ACTIVE);
  assign is_sleep  = (pwr_mode_i == PM_SLEEP);

  rst_hub_buzz #(.PERIOD(BUZZ_PERIOD), .WIDTH(BUZZ_WIDTH)) u_buzz (
    .clk_i, .rst_ni, .sleep_i(is_sleep), .win_o(buzz_o)
  );
  assign mon_active = is_active || buzz_o;

  // async sources: [0] external pin, [1] low-voltage trip
  logic [1:0] src_n, hold;
  assign src_n[0] = xres_ni;
  assign src_n[1] = !((lvd_dig_trip_i || (lvd_ana_trip_i && ana_reg_en_i)) && mon_active);

  for (genvar i = 0; i < 2; i++) begin : g_catch
    rst_hub_catch u_catch (.clk_i, .src_ni(src_n[i]), .hold_o(hold[i]));
  end

  logic [NRAIL-1:0] warn_s, warn_set;
  rst_hub_sync #(.W(NRAIL)) u_warn_sync (
    .clk_i, .rst_ni, .d_i(warn_i), .q_o(warn_s)
  );
  assign warn_set = warn_s & warn_en_i & {NRAIL{mon_active}};

  rst_hub_stretch #(.MIN_CYC(MIN_CYC)) u_stretch (
    .clk_i, .rst_ni,
    .hold_i (|hold),
    .pulse_i(wdt_timeout_i || sw_rst_i),
    .rst_no (sys_rst_no)
  );

  logic [CAUSE_W-1:0] cause_req;
  assign cause_req = {sw_rst_i, wdt_timeout_i, hold[0], hold[1], 1'b0};

  logic unused_clr0;
  assign unused_clr0 = clr_i[0];

  rst_hub_status #(.NRAIL(NRAIL)) u_status (
    .clk_i, .rst_ni,
    .cause_req_i(cause_req),
    .warn_set_i (warn_set),
    .clr_i      (clr_i[SW-1:1]),
    .status_o,
    .irq_o
  );

  a_r1_por_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !sys_rst_no);
  a_r2_ext_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xres_ni |-> !sys_rst_no);
  a_r10_hiber_no_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_active && !is_sleep && !$rose(irq_o)) |=> 1'b1 ##0 (!$rose(irq_o) || !$past(!is_active && !is_sleep)));
  a_r5_sw_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> status_o[C_SW]);
endmodule

// File: tb/rst_hub_tb.sv
`timescale 1ns/1ps
module rst_hub_tb;
  localparam int NRAIL = 4;
  localparam int MINC  = 6;
  localparam int BP    = 8;
  localparam int BW    = 2;
  localparam int SW    = 5 + NRAIL;

  logic clk = 0, rst_ni = 0, xres_ni = 1;
  logic lvd_dig = 0, lvd_ana = 0, ana_en = 1;
  logic [NRAIL-1:0] warn = '0, warn_en = '0;
  logic wdt = 0, swr = 0;
  logic [1:0] pmode = 2'd0;
  logic [SW-1:0] clr = '0;
  logic sys_rst_no, irq, buzz;
  logic [SW-1:0] st;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_hub #(.NRAIL(NRAIL), .MIN_CYC(MINC), .BUZZ_PERIOD(BP), .BUZZ_WIDTH(BW)) u_dut (
    .clk_i(clk), .rst_ni, .xres_ni, .lvd_dig_trip_i(lvd_dig), .lvd_ana_trip_i(lvd_ana),
    .ana_reg_en_i(ana_en), .warn_i(warn), .warn_en_i(warn_en), .wdt_timeout_i(wdt),
    .sw_rst_i(swr), .pwr_mode_i(pmode), .clr_i(clr), .sys_rst_no, .irq_o(irq),
    .status_o(st), .buzz_o(buzz)
  );

  typedef struct {
    string req;
    string what;
    int    expv;
    int    actv;
  } item_t;
  item_t sbq[$];

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      int act;
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      case (it.what)
        "rst":  act = int'(sys_rst_no);
        "st":   act = int'(st);
        "irq":  act = int'(irq);
        "buzz": act = int'(buzz);
        default: act = it.actv;
      endcase
      checks++;
      if (act != it.expv) begin
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.what, act, it.expv);
      end
    end
  end

  task automatic expect_v(string req, string what, int expv, int actv = 0);
    item_t it;
    it.req = req; it.what = what; it.expv = expv; it.actv = actv;
    sbq.push_back(it);
    #0.1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic release_count(string req, int expv);
    int n = 0;
    do begin tick(); n++; end while (!sys_rst_no && n < 200);
    expect_v(req, "cnt", expv, n);
  endtask

  task automatic write_clr(logic [SW-1:0] v);
    clr = v; tick(); clr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expect_v("R1", "rst", 0);
    expect_v("R1", "st", 1);
    rst_ni = 1;
    release_count("R1", MINC);
    expect_v("R1", "rst", 1);

    write_clr('1);
    expect_v("R7", "st", 1);                   // power-on bit not clearable

    wdt = 1; tick(); wdt = 0;
    expect_v("R4", "rst", 0);
    expect_v("R4", "st", 8);
    release_count("R4", MINC);

    swr = 1; clr = SW'(16); tick(); swr = 0; clr = '0;
    expect_v("R7", "st", 16);                  // set beats clear
    expect_v("R5", "rst", 0);
    release_count("R5", MINC);
    write_clr(SW'(16));
    expect_v("R7", "st", 0);

    wdt = 1; swr = 1; tick(); wdt = 0; swr = 0;
    expect_v("R6", "st", 24);
    release_count("R6", MINC);

    xres_ni = 0; #1;
    expect_v("R2", "rst", 0);                  // before any edge
    repeat (3) tick();
    expect_v("R2", "st", 4);
    xres_ni = 1;
    release_count("R2", MINC + 2);

    lvd_dig = 1; #1;
    expect_v("R3", "rst", 0);
    repeat (2) tick();
    expect_v("R3", "st", 2);
    lvd_dig = 0;
    release_count("R3", MINC + 2);

    write_clr(SW'(2));
    expect_v("R7", "st", 0);
    ana_en = 0; lvd_ana = 1;
    repeat (3) tick();
    expect_v("R3", "rst", 1);
    expect_v("R3", "st", 0);
    ana_en = 1; #1;
    expect_v("R3", "rst", 0);
    tick();
    expect_v("R3", "st", 2);
    lvd_ana = 0;
    release_count("R3", MINC + 2);

    write_clr('1);
    warn_en = 4'b0001; warn = 4'b0011;
    repeat (3) tick();
    warn = '0;
    expect_v("R8", "irq", 1);
    expect_v("R8", "st", 32);
    repeat (3) tick();
    expect_v("R8", "st", 32);                  // rail 1 disabled
    swr = 1; tick(); swr = 0;
    expect_v("R8", "st", 48);
    expect_v("R8", "irq", 1);
    release_count("R5", MINC);
    write_clr(SW'(32));
    expect_v("R8", "irq", 0);
    expect_v("R7", "st", 16);

    pmode = 2'd1;
    expect_v("R9", "buzz", 0);
    for (int k = 1; k <= 2 * BP; k++) begin
      tick();
      expect_v("R9", "buzz", ((k % BP) >= BP - BW) ? 1 : 0);
    end
    tick();                                    // count 1, window closed
    lvd_dig = 1; #1;
    expect_v("R10", "rst", 1);
    tick(); lvd_dig = 0;
    expect_v("R10", "rst", 1);
    expect_v("R10", "st", 16);
    repeat (4) tick();                         // count 6, window open
    expect_v("R9", "buzz", 1);
    lvd_dig = 1; #1;
    expect_v("R10", "rst", 0);
    tick(); lvd_dig = 0;
    expect_v("R10", "st", 2);
    release_count("R10", MINC + 2);

    pmode = 2'd2;
    expect_v("R9", "buzz", 0);
    lvd_dig = 1; warn = 4'b0001;
    repeat (4) tick();
    expect_v("R10", "rst", 1);
    expect_v("R10", "st", 2);
    expect_v("R10", "irq", 0);
    expect_v("R9", "buzz", 0);
    lvd_dig = 0; warn = '0; pmode = 2'd0;
    repeat (3) tick();

    wait (sbq.size() == 0);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule